// File: doc/BRIEF.md
# Serial port status flag unit

This block keeps the status flags of a serial port that runs either as an asynchronous UART or as a clocked synchronous link. It sits between the CPU register bus and the send and receive shift engines. The shift engines, the baud generator and the parity logic stay outside. They report to this block with single-cycle event pulses.

On the send side the block holds the transmit data register and a buffer-full flag. On the receive side it loads the receive data register when a reception completes. It detects overrun and raises a receive interrupt request. The CPU sees four flags in a read-only status word. Each read of that word returns the flags and then clears them.

Top module: `sio_status_flags`

## Requirements
- R1: After reset, `stat_q` is 0, `rx_irq` is 0, and `rx_data` and `tx_data` are 0.
- R2: A cycle with `stat_rd` high shows the current flags on `stat_q`. In the next cycle every flag is 0, unless an event in the read cycle sets it again.
- R3: `stat_q[3]` (buffer full) is 1 in the cycle after `tx_wr`. It is cleared in the cycle after `tx_load`. When `tx_wr` and `tx_load` fall in the same cycle, the flag ends up set.
- R4: `tx_wr` loads `tx_wdata` into `tx_data`, visible one cycle later. A write while the buffer is full replaces the pending word.
- R5: `stat_q[2]` (parity error) is set one cycle after `rx_par_bad`, in either mode.
- R6: When `rx_done` arrives while an earlier word is still unread and `rx_rd` is low, `stat_q[1]` (overrun) is set one cycle later and `rx_data` keeps the old word. Otherwise `rx_done` loads `rx_word` into `rx_data` one cycle later and marks it unread.
- R7: `rx_rd` clears the unread state. If `rx_rd` and `rx_done` fall in the same cycle, the new word loads and no overrun is flagged.
- R8: `stat_q[0]` (framing error) is set one cycle after `rx_start_bad` or `rx_stop_bad` only while `uart_mode` is 1. When `uart_mode` is 0 these pulses have no effect.
- R9: `rx_irq` pulses for one cycle, one cycle after a framing condition in UART mode or after a completion that loads `rx_data`. An overrun completion alone raises no pulse.
- R10: A flag-setting event in the same cycle as `stat_rd` leaves its flag set after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uart_mode | input | 1 | 1 = asynchronous mode, 0 = synchronous mode |
| tx_wr | input | 1 | CPU write strobe to the transmit buffer |
| tx_wdata | input | W | Data written to the transmit buffer |
| tx_load | input | 1 | Send engine has taken the buffer into its shift register |
| tx_data | output | W | Transmit buffer contents |
| rx_done | input | 1 | Reception complete pulse |
| rx_word | input | W | Word from the receive shift register |
| rx_par_bad | input | 1 | Parity mismatch pulse |
| rx_start_bad | input | 1 | Start-bit sample read 1 |
| rx_stop_bad | input | 1 | Stop-bit sample read 0 |
| rx_rd | input | 1 | CPU read strobe of the receive data register |
| rx_data | output | W | Receive data register |
| stat_rd | input | 1 | CPU read strobe of the status word |
| stat_q | output | 4 | Status: [3] buffer full, [2] parity, [1] overrun, [0] framing |
| rx_irq | output | 1 | Receive interrupt request pulse |

## Verification
All results come from one register stage. A flag, a data register or the interrupt pulse driven by an event in cycle N appears in cycle N+1. The only exception is the status value returned by a read, which is the one present during the read cycle itself. The bench drives inputs on the falling edge and advances its model at the rising edge. It compares every output at the next falling edge, so each check lands in the cycle where the result is due. Random traffic in both modes is mixed with directed cases: write/load collisions, overrun, a receive read coinciding with a completion, and events landing on a status read.

// File: rtl/sio_status_flags.sv
module sio_status_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         uart_mode,
  input  logic         tx_wr,
  input  logic [W-1:0] tx_wdata,
  input  logic         tx_load,
  output logic [W-1:0] tx_data,
  input  logic         rx_done,
  input  logic [W-1:0] rx_word,
  input  logic         rx_par_bad,
  input  logic         rx_start_bad,
  input  logic         rx_stop_bad,
  input  logic         rx_rd,
  output logic [W-1:0] rx_data,
  input  logic         stat_rd,
  output logic [3:0]   stat_q,
  output logic         rx_irq
);
  logic bfull, perr, oerr, ferr, rx_unread;

  wire frame_evt = uart_mode && (rx_start_bad || rx_stop_bad);
  wire rx_load   = rx_done && (!rx_unread || rx_rd);
  wire rx_ovr    = rx_done && rx_unread && !rx_rd;

  assign stat_q = {bfull, perr, oerr, ferr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bfull     <= 1'b0;
      perr      <= 1'b0;
      oerr      <= 1'b0;
      ferr      <= 1'b0;
      rx_unread <= 1'b0;
      rx_irq    <= 1'b0;
      tx_data   <= '0;
      rx_data   <= '0;
    end else begin
      if (tx_wr)                   bfull <= 1'b1;
      else if (tx_load || stat_rd) bfull <= 1'b0;

      if (rx_par_bad)   perr <= 1'b1;
      else if (stat_rd) perr <= 1'b0;

      if (rx_ovr)       oerr <= 1'b1;
      else if (stat_rd) oerr <= 1'b0;

      if (frame_evt)    ferr <= 1'b1;
      else if (stat_rd) ferr <= 1'b0;

      if (rx_load)    rx_unread <= 1'b1;
      else if (rx_rd) rx_unread <= 1'b0;

      if (tx_wr)   tx_data <= tx_wdata;
      if (rx_load) rx_data <= rx_word;
      rx_irq <= frame_evt || rx_load;
    end
  end
endmodule

module sio_status_flags_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         uart_mode,
  input logic         tx_wr,
  input logic         tx_load,
  input logic         rx_done,
  input logic         rx_par_bad,
  input logic         rx_start_bad,
  input logic         rx_stop_bad,
  input logic         rx_rd,
  input logic         stat_rd,
  input logic         rx_unread,
  input logic [W-1:0] rx_data,
  input logic [3:0]   stat_q,
  input logic         rx_irq
);
  a_r3_bfull_set: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> stat_q[3]);

  a_r5_parity_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_par_bad |=> stat_q[2]);

  a_r6_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_unread && !rx_rd) |=> ($stable(rx_data) && stat_q[1]));

  a_r8_uart_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!uart_mode && !stat_q[0] && !stat_rd) |=> !stat_q[0]);

  a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !tx_wr && !rx_par_bad && !rx_done && !rx_start_bad && !rx_stop_bad)
    |=> stat_q == 4'b0);

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_done && !(uart_mode && (rx_start_bad || rx_stop_bad))) |=> !rx_irq);
endmodule

bind sio_status_flags sio_status_flags_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .uart_mode(uart_mode), .tx_wr(tx_wr),
  .tx_load(tx_load), .rx_done(rx_done), .rx_par_bad(rx_par_bad),
  .rx_start_bad(rx_start_bad), .rx_stop_bad(rx_stop_bad), .rx_rd(rx_rd),
  .stat_rd(stat_rd), .rx_unread(rx_unread), .rx_data(rx_data),
  .stat_q(stat_q), .rx_irq(rx_irq)
);

// File: tb/sim_sio_status_flags.sv
module sim_sio_status_flags;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic uart_mode = 1'b1, tx_wr = 1'b0, tx_load = 1'b0, rx_done = 1'b0;
  logic rx_par_bad = 1'b0, rx_start_bad = 1'b0, rx_stop_bad = 1'b0;
  logic rx_rd = 1'b0, stat_rd = 1'b0;
  logic [W-1:0] tx_wdata = '0, rx_word = '0;
  logic [W-1:0] tx_data, rx_data;
  logic [3:0] stat_q;
  logic rx_irq;

  int checks = 0, fails = 0;
  logic m_bf = 0, m_pe = 0, m_oe = 0, m_fe = 0, m_unread = 0, m_irq = 0;
  logic [W-1:0] m_txd = '0, m_rxd = '0;

  always #2 clk = ~clk;

  sio_status_flags #(.W(W)) u0 (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  function automatic logic nxt_flag(logic cur, logic set, logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

  task automatic step();
    logic fr, ld, ov;
    @(posedge clk);
    fr = uart_mode && (rx_start_bad || rx_stop_bad);
    ld = rx_done && (!m_unread || rx_rd);
    ov = rx_done && m_unread && !rx_rd;
    m_bf = nxt_flag(m_bf, tx_wr, tx_load || stat_rd);
    m_pe = nxt_flag(m_pe, rx_par_bad, stat_rd);
    m_oe = nxt_flag(m_oe, ov, stat_rd);
    m_fe = nxt_flag(m_fe, fr, stat_rd);
    m_unread = nxt_flag(m_unread, ld, rx_rd);
    if (tx_wr) m_txd = tx_wdata;
    if (ld) m_rxd = rx_word;
    m_irq = fr || ld;
    @(negedge clk);
    check("R3 bfull", stat_q[3], m_bf);
    check("R5 perr", stat_q[2], m_pe);
    check("R6 oerr", stat_q[1], m_oe);
    check("R8 ferr", stat_q[0], m_fe);
    check("R4 tx_data", tx_data, m_txd);
    check("R6 rx_data", rx_data, m_rxd);
    check("R9 rx_irq", rx_irq, m_irq);
    {tx_wr, tx_load, rx_done, rx_par_bad, rx_start_bad, rx_stop_bad, rx_rd, stat_rd} = '0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 stat", stat_q, 4'h0);
    check("R1 irq", rx_irq, 1'b0);
    check("R1 rxd", rx_data, 8'h00);
    check("R1 txd", tx_data, 8'h00);
    rst_n = 1'b1;
    step();

    // R3 / R4: write, overwrite, load
    tx_wr = 1; tx_wdata = 8'hA5; step();
    tx_wr = 1; tx_wdata = 8'h3C; step();
    check("R4 overwrite", tx_data, 8'h3C);
    tx_load = 1; step();
    check("R3 cleared", stat_q[3], 1'b0);
    tx_wr = 1; tx_load = 1; tx_wdata = 8'h11; step();
    check("R3 collision set", stat_q[3], 1'b1);

    // R2: read returns flags then clears
    rx_par_bad = 1; step();
    stat_rd = 1;
    check("R2 read value", stat_q, 4'b1100);
    step();
    check("R2 cleared", stat_q, 4'h0);

    // R6 / R7: overrun, then simultaneous read
    rx_done = 1; rx_word = 8'h5A; step();
    check("R9 load irq", rx_irq, 1'b1);
    rx_done = 1; rx_word = 8'hC3; step();
    check("R6 kept old", rx_data, 8'h5A);
    check("R6 overrun", stat_q[1], 1'b1);
    check("R9 no irq on overrun", rx_irq, 1'b0);
    rx_done = 1; rx_rd = 1; rx_word = 8'h77; step();
    check("R7 loaded on read", rx_data, 8'h77);
    rx_rd = 1; step();
    rx_done = 1; rx_word = 8'h12; step();
    check("R7 normal load", rx_data, 8'h12);
    stat_rd = 1; rx_rd = 1; step();

    // R8: sync mode ignores framing
    uart_mode = 0; rx_start_bad = 1; rx_stop_bad = 1; step();
    check("R8 sync ignored", stat_q[0], 1'b0);
    check("R8 sync no irq", rx_irq, 1'b0);
    uart_mode = 1; rx_stop_bad = 1; step();
    check("R8 uart stop", stat_q[0], 1'b1);
    check("R9 frame irq", rx_irq, 1'b1);

    // R10: event during read wins
    stat_rd = 1; rx_start_bad = 1; rx_par_bad = 1; step();
    check("R10 event wins", stat_q, 4'b0101);

    for (int i = 0; i < 3000; i++) begin
      uart_mode    = ($urandom % 4) != 0;
      tx_wr        = ($urandom % 6) == 0;
      tx_wdata     = W'($urandom);
      tx_load      = ($urandom % 6) == 0;
      rx_done      = ($urandom % 5) == 0;
      rx_word      = W'($urandom);
      rx_par_bad   = ($urandom % 10) == 0;
      rx_start_bad = ($urandom % 12) == 0;
      rx_stop_bad  = ($urandom % 12) == 0;
      rx_rd        = ($urandom % 4) == 0;
      stat_rd      = ($urandom % 5) == 0;
      step();
    end
    summary();
  end
endmodule